// File: doc/BRIEF.md
# Two-Counter Pulse-Width Modulator

This block produces a pulse-width-modulated signal from two cooperating down-counters. A period counter runs as a self-reloading interval timer. Each time it wraps, it emits a one-clock tick. Each tick restarts a width counter that works as a one-shot. The width counter drives the output active for the programmed number of count clocks, then stops at zero and waits for the next tick.

Both the period value and the width value sit in holding registers, and software may write them at any time. The counters copy those values only when a tick event occurs. As a result, a single write never changes the cycle that is already running. To change both values together, software should write both right after a tick, so that they take effect at the following tick.

Counting advances only on system-clock cycles where the count-clock enable strobe is high. A separate run control starts and halts the pair.

Top module: `dual_counter_pwm`

## Requirements
- R1: Reset sets both holding registers to zero, clears both counters, and drives `tick` and `pwm_out` low. If run is raised with no writes afterwards, `tick` pulses on every enabled count clock and `pwm_out` stays low.
- R2: When `run` is sampled high while the block is stopped, the period counter loads the period register, whatever `cnt_en` is. `tick` is high for exactly the next system-clock cycle.
- R3: With a period value P and `cnt_en` held high, the gap from one `tick` to the next is exactly P+1 clocks. Each tick is one system clock wide.
- R4: The counters only advance on clocks where `cnt_en` is high. While `cnt_en` stays low during a run, no further `tick` appears and `pwm_out` holds its level.
- R5: `pwm_out` goes active at the first enabled count clock after a tick event, never at the tick event itself.
- R6: With duty value D and 0 < D < P+1, `pwm_out` is high for exactly D of every P+1 count clocks.
- R7: A duty value of 0 keeps `pwm_out` low at all times.
- R8: A duty value of P+1 or more keeps `pwm_out` high through every period. The value is clamped to P+1 rather than wrapping.
- R9: A write to either holding register takes effect only at the next tick event. The period and width that are already running finish unchanged.
- R10: Once `run` is sampled low, both counters clear. From the next clock, `pwm_out` and `tick` are low. Raising `run` again restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count-clock enable strobe |
| run | input | 1 | High to count, low to halt and clear |
| period_we | input | 1 | Write strobe for the period register |
| period_wdata | input | WIDTH | Period value P (period is P+1 count clocks) |
| duty_we | input | 1 | Write strobe for the duty register |
| duty_wdata | input | WIDTH | Active width D in count clocks |
| tick | output | 1 | One-clock pulse at each period reload |
| pwm_out | output | 1 | Modulated output, active high |

## Verification
The hardest situation to reach is a register write that lands in the middle of a running period. The bench has to show that the old period still finishes to the exact count clock before the new values appear. To get there, the stimulus locks onto a tick and steps a known number of clocks into the period. It then writes new period and duty values and counts the clocks to the next tick, which must match the old period. A second hard case is the enable strobe arriving sparsely or irregularly. For this, a pseudo-random enable pattern runs while a behavioural model is compared with the outputs on every clock.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;
   typedef enum logic {
      PER_IDLE = 1'b0,
      PER_RUN  = 1'b1
   } per_state_e;
endpackage

// File: rtl/dcpwm_period_ctr.sv
module dcpwm_period_ctr
   import dcpwm_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             cnt_en,
   input  logic [WIDTH-1:0] period_val,
   output logic             reload_evt,
   output logic             running
);
   per_state_e       state_q;
   logic [WIDTH-1:0] cnt_q;

   assign reload_evt = run && ((state_q == PER_IDLE) || (cnt_en && (cnt_q == '0)));
   assign running    = (state_q == PER_RUN);

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         state_q <= PER_IDLE;
         cnt_q   <= '0;
      end else if (reload_evt) begin
         state_q <= PER_RUN;
         cnt_q   <= period_val;
      end else if (cnt_en) begin
         cnt_q   <= cnt_q - WIDTH'(1);
      end
   end

   // R3: a nonzero count steps down by exactly one on an enabled clock
   assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
      (run && running && cnt_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - WIDTH'(1)));

   // R4: without the enable strobe the running count holds
   assert_hold_no_en_R4: assert property (@(posedge clk) disable iff (rst)
      (run && running && !cnt_en) |=> $stable(cnt_q));

   // R10: halting clears the counter
   assert_halt_clear_R10: assert property (@(posedge clk) disable iff (rst)
      !run |=> (cnt_q == '0 && !running));
endmodule

// File: rtl/dcpwm_width_ctr.sv
module dcpwm_width_ctr #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             cnt_en,
   input  logic             reload_evt,
   input  logic [WIDTH-1:0] period_val,
   input  logic [WIDTH-1:0] duty_val,
   output logic             out_q
);
   localparam int SW = WIDTH + 1;

   logic [SW-1:0] limit;
   logic [SW-1:0] duty_ext;
   logic [SW-1:0] load_val;
   logic [SW-1:0] cnt_q;

   assign limit    = {1'b0, period_val} + SW'(1);
   assign duty_ext = {1'b0, duty_val};
   assign load_val = (duty_ext > limit) ? limit : duty_ext;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else begin
         if (cnt_en) out_q <= (cnt_q != '0);
         if (reload_evt)
            cnt_q <= load_val;
         else if (cnt_en && cnt_q != '0)
            cnt_q <= cnt_q - SW'(1);
      end
   end

   // R5: the output only rises on an enabled count clock
   assert_rise_on_en_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(out_q) |-> $past(cnt_en));

   // R6: an exhausted one-shot stays at zero until the next reload
   assert_zero_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (run && !reload_evt && cnt_q == '0) |=> (cnt_q == '0));

   // R10: halting forces the output inactive
   assert_halt_low_R10: assert property (@(posedge clk) disable iff (rst)
      !run |=> !out_q);
endmodule

// File: rtl/dual_counter_pwm.sv
module dual_counter_pwm #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_en,
   input  logic             run,
   input  logic             period_we,
   input  logic [WIDTH-1:0] period_wdata,
   input  logic             duty_we,
   input  logic [WIDTH-1:0] duty_wdata,
   output logic             tick,
   output logic             pwm_out
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dual_counter_pwm: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] period_q;
   logic [WIDTH-1:0] duty_q;
   logic             reload_evt;
   logic             running;
   logic             tick_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         period_q <= '0;
         duty_q   <= '0;
         tick_q   <= 1'b0;
      end else begin
         if (period_we) period_q <= period_wdata;
         if (duty_we)   duty_q   <= duty_wdata;
         tick_q <= reload_evt;
      end
   end

   dcpwm_period_ctr #(.WIDTH(WIDTH)) u_period (
      .clk        (clk),
      .rst        (rst),
      .run        (run),
      .cnt_en     (cnt_en),
      .period_val (period_q),
      .reload_evt (reload_evt),
      .running    (running)
   );

   dcpwm_width_ctr #(.WIDTH(WIDTH)) u_width (
      .clk        (clk),
      .rst        (rst),
      .run        (run),
      .cnt_en     (cnt_en),
      .reload_evt (reload_evt),
      .period_val (period_q),
      .duty_val   (duty_q),
      .out_q      (pwm_out)
   );

   assign tick = tick_q;

   // R2: a start from the stopped state always yields a tick next clock
   assert_start_tick_R2: assert property (@(posedge clk) disable iff (rst)
      (run && !running) |=> tick);

   // R10: no tick follows a clock where run was low
   assert_no_tick_halted_R10: assert property (@(posedge clk) disable iff (rst)
      tick |-> $past(run));
endmodule

// File: tb/dual_counter_pwm_tb_top.sv
module dual_counter_pwm_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cnt_en = 1'b0;
   logic         run = 1'b0;
   logic         period_we = 1'b0;
   logic [W-1:0] period_wdata = '0;
   logic         duty_we = 1'b0;
   logic [W-1:0] duty_wdata = '0;
   logic         tick;
   logic         pwm_out;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   int en_mode = 0;
   logic [7:0] lfsr = 8'hA5;
   string cur_req = "R1";

   // reference model state
   int  m_act = 0, m_mcnt = 0, m_scnt = 0, m_per = 0, m_duty = 0;
   bit  m_out = 0, m_tick = 0;

   always #5 clk = ~clk;

   dual_counter_pwm #(.WIDTH(W)) dut_i (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .run(run),
      .period_we(period_we), .period_wdata(period_wdata),
      .duty_we(duty_we), .duty_wdata(duty_wdata),
      .tick(tick), .pwm_out(pwm_out)
   );

   always @(posedge clk) begin
      bit evt;
      int lim, dc;
      if (rst) begin
         m_act = 0; m_mcnt = 0; m_scnt = 0; m_per = 0; m_duty = 0;
         m_out = 0; m_tick = 0;
      end else begin
         evt = run && (m_act == 0 || (cnt_en && m_mcnt == 0));
         lim = m_per + 1;
         dc  = (m_duty > lim) ? lim : m_duty;
         m_tick = evt;
         if (!run) begin
            m_act = 0; m_mcnt = 0; m_scnt = 0; m_out = 0;
         end else begin
            if (cnt_en) m_out = (m_scnt != 0);
            if (evt) m_scnt = dc;
            else if (cnt_en && m_scnt != 0) m_scnt = m_scnt - 1;
            if (evt) begin m_act = 1; m_mcnt = m_per; end
            else if (cnt_en) m_mcnt = m_mcnt - 1;
         end
         if (period_we) m_per = int'(period_wdata);
         if (duty_we) m_duty = int'(duty_wdata);
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
         summary();
      end
   end

   task automatic check(string req, int act, int exp, string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one clock: compare at negedge, then drive next inputs
   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!rst) begin
            check(cur_req, int'(tick), int'(m_tick), "tick vs model");
            check(cur_req, int'(pwm_out), int'(m_out), "pwm vs model");
         end
         period_we = 1'b0;
         duty_we   = 1'b0;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         case (en_mode)
            0: cnt_en = 1'b1;
            1: cnt_en = (cyc % 3 == 0);
            2: cnt_en = lfsr[0];
            default: cnt_en = 1'b0;
         endcase
      end
   endtask

   task automatic write_regs(int p, int d);
      period_we = 1'b1; period_wdata = W'(p);
      duty_we   = 1'b1; duty_wdata   = W'(d);
   endtask

   task automatic wait_tick();
      int g = 0;
      step();
      while (tick !== 1'b1 && g < 2000) begin step(); g++; end
   endtask

   // write P,D, let one tick pass, then count high samples over one period
   task automatic check_duty(int p, int d, string req);
      int highs = 0;
      int expv;
      en_mode = 0;
      write_regs(p, d);
      wait_tick();
      wait_tick();
      for (int i = 0; i < p + 1; i++) begin
         step();
         if (pwm_out === 1'b1) highs++;
      end
      expv = (d > p + 1) ? p + 1 : d;
      check(req, highs, expv, "active clocks in one period");
   endtask

   task automatic check_period(int p, string req);
      int gap = 0;
      en_mode = 0;
      wait_tick();
      step();
      gap = 1;
      while (tick !== 1'b1 && gap < 2000) begin step(); gap++; end
      check(req, gap, p + 1, "clocks between ticks");
   endtask

   initial begin
      int pwm_hold;
      int t_seen;
      step(3);
      rst = 1'b0;
      // R1: reset state
      cur_req = "R1";
      @(negedge clk);
      check("R1", int'(tick), 0, "tick after reset");
      check("R1", int'(pwm_out), 0, "pwm after reset");
      run = 1'b1;
      step(10);
      check("R1", int'(tick), 1, "zero period ticks every clock");
      check("R1", int'(pwm_out), 0, "zero duty stays low");

      // R2: start from stopped with enable low
      cur_req = "R2";
      run = 1'b0; en_mode = 3;
      write_regs(3, 2);
      step(2);
      run = 1'b1;
      step();
      check("R2", int'(tick), 1, "tick right after start");
      step();
      check("R2", int'(tick), 0, "tick is one clock wide");

      cur_req = "R3";
      check_period(3, "R3");
      check_period(3, "R3");
      cur_req = "R5";
      en_mode = 0;
      wait_tick();
      check("R5", int'(pwm_out), 0, "not active at tick sample");
      step();
      check("R5", int'(pwm_out), 1, "active one count clock later");

      cur_req = "R6"; check_duty(3, 2, "R6");
      check_duty(5, 5, "R6");
      check_duty(6, 1, "R6");
      cur_req = "R7"; check_duty(3, 0, "R7");
      check_duty(9, 0, "R7");
      cur_req = "R8"; check_duty(3, 4, "R8");
      check_duty(3, 9, "R8");
      check_duty(0, 1, "R8");
      check_duty(4, 16'hFFFF, "R8");

      // R4: sparse and random enables
      cur_req = "R4";
      write_regs(4, 2);
      en_mode = 1; step(90);
      en_mode = 2; step(120);
      en_mode = 3; step(2);
      pwm_hold = int'(pwm_out);
      t_seen = 0;
      for (int i = 0; i < 12; i++) begin
         step();
         if (tick === 1'b1) t_seen++;
         check("R4", int'(pwm_out), pwm_hold, "pwm holds without enable");
      end
      check("R4", t_seen, 0, "no tick without enable");

      // R9: mid-period write keeps running period
      cur_req = "R9";
      en_mode = 0;
      write_regs(7, 3);
      wait_tick(); wait_tick();
      step(2);
      write_regs(2, 1);
      t_seen = 0;
      for (int i = 0; i < 6; i++) begin
         step();
         if (tick === 1'b1) t_seen = i + 1;
      end
      check("R9", t_seen, 6, "old period finishes after write");
      check_period(2, "R9");

      // R10: halt and restart
      cur_req = "R10";
      write_regs(3, 4);
      wait_tick(); wait_tick(); step(2);
      run = 1'b0;
      step();
      check("R10", int'(pwm_out), 0, "pwm low after halt");
      check("R10", int'(tick), 0, "tick low after halt");
      step(5);
      check("R10", int'(pwm_out), 0, "pwm stays low while halted");
      run = 1'b1;
      step();
      check("R10", int'(tick), 1, "restart ticks");
      step(20);
      summary();
   end
endmodule